// File: doc/BRIEF.md
# Paged Memory Address Former

This block builds the memory address register for a 16-bit word machine whose 15-bit address space is cut into 1024-word pages. An instruction holds only a 10-bit offset. Its bit 10 decides whether the page bits of the address register are cleared, which selects page 0, or left as they are, which selects the current page. Its bit 15 asks for an indirect step. In an indirect step, the word read from memory supplies a full 15-bit address, and that word's own bit 15 can ask for a further step.

The sequencer drives a phase code together with an advance strobe. The codes are fetch = 0, operand reference = 1, indirect = 2 and execute = 3. On each advance the block loads the register from the program counter, from the instruction or from the indirect word. It raises a flag while an indirect phase is still owed. It also marks operand addresses that fall outside the program's own page. Two combinational outputs give the page number of the register and the page number of any query address.

Top module: `paged_addr_former`

## Requirements
- R1: On an advance with phase code 1, address bits 9..0 take instruction bits 9..0. Instruction bits 14..11 have no effect on the address.
- R2: On phase code 1 with instruction bit 10 clear, address bits 14..10 become zero, so the reference lands on page 0.
- R3: On phase code 1 with instruction bit 10 set, address bits 14..10 keep their previous value. From octal 02775 the reachable range is octal 02000 to 03777, and octal 04000 cannot be reached.
- R4: After phase code 1, indirect_req equals instruction bit 15.
- R5: On phase code 2 while indirect_req is high, the address becomes indirect-word bits 14..0. Bit 15 of that word is never an address bit.
- R6: After a phase code 2 load, indirect_req equals indirect-word bit 15. When that bit is set the chain continues, and when it is clear the chain ends.
- R7: Phase code 2 while indirect_req is low is ignored. The address, indirect_req and cross_page do not change.
- R8: On phase code 0 the address becomes p_addr, and both indirect_req and cross_page clear.
- R9: m_page is address bits 14..10 and q_page is q_addr bits 14..10, both combinational.
- R10: After a phase code 1 load or an accepted phase code 2 load, cross_page is high exactly when the loaded page differs from the page of p_addr in that cycle.
- R11: With the advance strobe low, or with phase code 3, every registered output holds its value.
- R12: While reset is low, the address, indirect_req and cross_page are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv | input | 1 | Advance strobe: the phase code is acted on this cycle |
| phase | input | 2 | Phase code: 0 fetch, 1 operand reference, 2 indirect, 3 execute |
| t_word | input | 16 | Instruction word |
| ind_word | input | 16 | Word read from memory during an indirect step |
| p_addr | input | 15 | Program counter |
| q_addr | input | 15 | Address whose page number is wanted |
| m_addr | output | 15 | Memory address register |
| m_page | output | 5 | Page number of m_addr |
| q_page | output | 5 | Page number of q_addr |
| indirect_req | output | 1 | An indirect phase is still owed |
| cross_page | output | 1 | The last operand address lies outside the program's page |

## Verification
Every registered result (m_addr, indirect_req and cross_page) becomes valid on the first rising edge after an advance is presented. m_page follows m_addr within that same cycle. The bench drives each advance on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge, where all three registered outputs are compared against values it computes itself. q_page has no register on its path, so it is checked one time unit after q_addr changes, well away from any edge.

// File: rtl/pamf_pkg.sv
package pamf_pkg;
  localparam int WORD_W_D = 16;
  localparam int ADDR_W_D = 15;
  localparam int OFS_W_D  = 10;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_OPREF = 2'd1,
    PH_INDIR = 2'd2,
    PH_EXEC  = 2'd3
  } phase_e;
endpackage

// File: rtl/pamf_operand_mux.sv
// Forms the operand address from the instruction offset and the current page bits.
module pamf_operand_mux #(
  parameter int WORD_W = pamf_pkg::WORD_W_D,
  parameter int ADDR_W = pamf_pkg::ADDR_W_D,
  parameter int OFS_W  = pamf_pkg::OFS_W_D
) (
  input  logic [WORD_W-1:0] t_word,
  input  logic [ADDR_W-1:0] m_cur,
  output logic [ADDR_W-1:0] opnd_addr,
  output logic              opnd_ind
);
  localparam int PAGE_W  = ADDR_W - OFS_W;
  localparam int SEL_BIT = OFS_W;
  localparam int IND_BIT = WORD_W - 1;

  function automatic logic [ADDR_W-1:0] form_operand(
    input logic [WORD_W-1:0] t,
    input logic [ADDR_W-1:0] m
  );
    logic [PAGE_W-1:0] pg;
    pg = t[SEL_BIT] ? m[ADDR_W-1:OFS_W] : '0;
    return {pg, t[OFS_W-1:0]};
  endfunction

  logic unused_tbits;
  assign unused_tbits = ^t_word[IND_BIT-1:SEL_BIT+1];

  assign opnd_addr = form_operand(t_word, m_cur);
  assign opnd_ind  = t_word[IND_BIT];
endmodule

// File: rtl/pamf_page_view.sv
// Page number of an address, and comparison of two pages.
module pamf_page_view #(
  parameter int ADDR_W = pamf_pkg::ADDR_W_D,
  parameter int OFS_W  = pamf_pkg::OFS_W_D
) (
  input  logic [ADDR_W-1:0]       addr_a,
  input  logic [ADDR_W-1:0]       addr_b,
  output logic [ADDR_W-OFS_W-1:0] page_a,
  output logic                    pages_differ
);
  function automatic logic [ADDR_W-OFS_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  assign page_a       = page_of(addr_a);
  assign pages_differ = page_of(addr_a) != page_of(addr_b);
endmodule

// File: rtl/pamf_mreg.sv
// Address register and its two flags.
module pamf_mreg #(
  parameter int ADDR_W = pamf_pkg::ADDR_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_ind,
  input  logic              ld_cross,
  output logic [ADDR_W-1:0] m_q,
  output logic              ind_q,
  output logic              cross_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q     <= '0;
      ind_q   <= 1'b0;
      cross_q <= 1'b0;
    end else if (ld_en) begin
      m_q     <= ld_addr;
      ind_q   <= ld_ind;
      cross_q <= ld_cross;
    end
  end
endmodule

// File: rtl/paged_addr_former.sv
module paged_addr_former #(
  parameter int WORD_W = pamf_pkg::WORD_W_D,
  parameter int ADDR_W = pamf_pkg::ADDR_W_D,
  parameter int OFS_W  = pamf_pkg::OFS_W_D,
  parameter int PAGE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [1:0]        phase,
  input  logic [WORD_W-1:0] t_word,
  input  logic [WORD_W-1:0] ind_word,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [ADDR_W-1:0] q_addr,
  output logic [ADDR_W-1:0] m_addr,
  output logic [PAGE_W-1:0] m_page,
  output logic [PAGE_W-1:0] q_page,
  output logic              indirect_req,
  output logic              cross_page
);
  import pamf_pkg::*;

  localparam int NVIEW = 2;

  logic [ADDR_W-1:0] opnd_addr;
  logic              opnd_ind;
  logic              ld_fetch, ld_operand, ld_indirect, ind_ignored, ld_en;
  logic [ADDR_W-1:0] ld_addr;
  logic              ld_ind, ld_cross, ld_differ;
  logic [PAGE_W-1:0] ld_page;

  pamf_operand_mux #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) opnd_i (
    .t_word   (t_word),
    .m_cur    (m_addr),
    .opnd_addr(opnd_addr),
    .opnd_ind (opnd_ind)
  );

  always_comb begin
    ld_fetch    = adv && (phase == PH_FETCH);
    ld_operand  = adv && (phase == PH_OPREF);
    ld_indirect = adv && (phase == PH_INDIR) && indirect_req;
    ind_ignored = adv && (phase == PH_INDIR) && !indirect_req;
    ld_en       = ld_fetch || ld_operand || ld_indirect;
  end

  always_comb begin
    if (ld_fetch)        ld_addr = p_addr;
    else if (ld_operand) ld_addr = opnd_addr;
    else                 ld_addr = ind_word[ADDR_W-1:0];
    if (ld_operand)       ld_ind = opnd_ind;
    else if (ld_indirect) ld_ind = ind_word[WORD_W-1];
    else                  ld_ind = 1'b0;
    ld_cross = (ld_operand || ld_indirect) && ld_differ;
  end

  pamf_page_view #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) ldcmp_i (
    .addr_a      (ld_addr),
    .addr_b      (p_addr),
    .page_a      (ld_page),
    .pages_differ(ld_differ)
  );

  logic unused_ldpage;
  assign unused_ldpage = ^ld_page ^ ind_ignored;

  pamf_mreg #(.ADDR_W(ADDR_W)) mreg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_ind  (ld_ind),
    .ld_cross(ld_cross),
    .m_q     (m_addr),
    .ind_q   (indirect_req),
    .cross_q (cross_page)
  );

  logic [ADDR_W-1:0] view_addr [NVIEW];
  logic [PAGE_W-1:0] view_page [NVIEW];
  logic [NVIEW-1:0]  view_diff;
  assign view_addr[0] = m_addr;
  assign view_addr[1] = q_addr;

  for (genvar g = 0; g < NVIEW; g++) begin : g_view
    pamf_page_view #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) pv_i (
      .addr_a      (view_addr[g]),
      .addr_b      (p_addr),
      .page_a      (view_page[g]),
      .pages_differ(view_diff[g])
    );
  end

  logic unused_vdiff;
  assign unused_vdiff = ^view_diff;

  assign m_page = view_page[0];
  assign q_page = view_page[1];
endmodule

// File: rtl/paged_addr_former_chk.sv
module paged_addr_former_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic [1:0]        phase,
  input logic [WORD_W-1:0] t_word,
  input logic [WORD_W-1:0] ind_word,
  input logic [ADDR_W-1:0] p_addr,
  input logic [ADDR_W-1:0] m_addr,
  input logic              indirect_req,
  input logic              cross_page
);
  logic opref, indir, fetch;
  assign opref = adv && phase == 2'd1;
  assign indir = adv && phase == 2'd2;
  assign fetch = adv && phase == 2'd0;

  logic unused_chk;
  assign unused_chk = ^t_word[WORD_W-2:OFS_W+1];

  // R1
  offset_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opref |=> m_addr[OFS_W-1:0] == $past(t_word[OFS_W-1:0]));
  // R2
  base_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opref && !t_word[OFS_W] |=> m_addr[ADDR_W-1:OFS_W] == '0);
  // R3
  current_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opref && t_word[OFS_W] |=> m_addr[ADDR_W-1:OFS_W] == $past(m_addr[ADDR_W-1:OFS_W]));
  // R4
  ind_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opref |=> indirect_req == $past(t_word[WORD_W-1]));
  // R5
  ind_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    indir && indirect_req |=> m_addr == $past(ind_word[ADDR_W-1:0]));
  // R6
  ind_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    indir && indirect_req |=> indirect_req == $past(ind_word[WORD_W-1]));
  // R7
  ind_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    indir && !indirect_req |=> $stable(m_addr) && $stable(cross_page) && !indirect_req);
  // R8
  fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> m_addr == $past(p_addr) && !indirect_req && !cross_page);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv || phase == 2'd3 |=> $stable(m_addr) && $stable(indirect_req) && $stable(cross_page));
endmodule

bind paged_addr_former paged_addr_former_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .adv(adv), .phase(phase), .t_word(t_word),
  .ind_word(ind_word), .p_addr(p_addr), .m_addr(m_addr),
  .indirect_req(indirect_req), .cross_page(cross_page)
);

// File: tb/paged_addr_former_tb_top.sv
module paged_addr_former_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 1'b0;
  logic [1:0]  phase = 2'd0;
  logic [15:0] t_word = '0;
  logic [15:0] ind_word = '0;
  logic [14:0] p_addr = '0;
  logic [14:0] q_addr = '0;
  logic [14:0] m_addr;
  logic [4:0]  m_page, q_page;
  logic        indirect_req, cross_page;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam logic [1:0] FET = 2'd0, OPR = 2'd1, IND = 2'd2, EXE = 2'd3;

  paged_addr_former dut_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .phase(phase), .t_word(t_word),
    .ind_word(ind_word), .p_addr(p_addr), .q_addr(q_addr), .m_addr(m_addr),
    .m_page(m_page), .q_page(q_page), .indirect_req(indirect_req),
    .cross_page(cross_page)
  );

  always #5 clk = ~clk;

  function automatic int pg(input int a);
    return a / 1024;
  endfunction

  task automatic expect_state(input string req, input int em, input bit ei, input bit ec);
    checks++;
    if (m_addr !== 15'(em) || indirect_req !== ei || cross_page !== ec || m_page !== 5'(pg(em))) begin
      failures++;
      $display("FAIL %s: m=%o ind=%0b cross=%0b page=%0d, expected m=%o ind=%0b cross=%0b page=%0d",
               req, m_addr, indirect_req, cross_page, m_page, em, ei, ec, pg(em));
    end
  endtask

  task automatic step(input bit a, input logic [1:0] ph, input logic [15:0] t,
                      input logic [15:0] w, input logic [14:0] p);
    @(negedge clk);
    adv = a; phase = ph; t_word = t; ind_word = w; p_addr = p;
    @(negedge clk);
    adv = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_state("R12", 0, 0, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_direct_page0();
    step(1, FET, 0, 0, 15'o02775);
    expect_state("R8", 'o02775, 0, 0);
    step(1, OPR, 16'o001777, 0, 15'o02775);
    expect_state("R2", 'o01777, 0, 1);
    step(1, FET, 0, 0, 15'o02775);
    step(1, OPR, 16'o074321, 0, 15'o02775);
    expect_state("R1", 'o00321, 0, 1);
  endtask

  task automatic t_current_page();
    step(1, FET, 0, 0, 15'o02775);
    step(1, OPR, 16'o002000, 0, 15'o02775);
    expect_state("R3", 'o02000, 0, 0);
    step(1, OPR, 16'o003777, 0, 15'o02775);
    expect_state("R3", 'o03777, 0, 0);
  endtask

  task automatic t_indirect_chain();
    step(1, FET, 0, 0, 15'o02776);
    step(1, OPR, 16'o103777, 0, 15'o02776);
    expect_state("R4", 'o03777, 1, 0);
    step(1, IND, 0, 16'o104000, 15'o02776);
    expect_state("R6", 'o04000, 1, 1);
    step(1, IND, 0, 16'o000005, 15'o02776);
    expect_state("R5", 'o00005, 0, 1);
    step(1, IND, 0, 16'o012345, 15'o02776);
    expect_state("R7", 'o00005, 0, 1);
    step(1, EXE, 16'o177777, 16'o177777, 15'o02776);
    expect_state("R11", 'o00005, 0, 1);
    step(0, FET, 0, 0, 15'o02777);
    expect_state("R11", 'o00005, 0, 1);
    step(1, FET, 0, 0, 15'o02777);
    expect_state("R8", 'o02777, 0, 0);
  endtask

  task automatic t_high_page();
    step(1, FET, 0, 0, 15'o77775);
    step(1, OPR, 16'o102000, 0, 15'o77775);
    expect_state("R10", 'o76000, 1, 0);
    step(1, IND, 0, 16'o077001, 15'o77775);
    expect_state("R10", 'o77001, 0, 0);
    step(1, OPR, 16'o000000, 0, 15'o77775);
    expect_state("R2", 0, 0, 1);
  endtask

  task automatic t_query();
    int vals [4] = '{'o77777, 'o04000, 'o01777, 'o12000};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      q_addr = 15'(vals[i]);
      #1;
      checks++;
      if (q_page !== 5'(pg(vals[i]))) begin
        failures++;
        $display("FAIL R9: q_page=%0d expected %0d", q_page, pg(vals[i]));
      end
    end
  endtask

  initial begin
    t_reset();
    t_direct_page0();
    t_current_page();
    t_indirect_chain();
    t_high_page();
    t_query();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule